// File: doc/BRIEF.md
# Bidirectional Port with Peripheral Override

This block is a six-pin general-purpose I/O port whose upper pins can be handed over to a serial peripheral. Software sees three registers on a small register bus: a port data latch, a per-pin direction register and a control register holding a single open-drain bit that applies to every pin at once. The pads are modelled as three vectors: a drive enable per pin, the value driven while that enable is high, and the raw level seen on the pin. Each raw level passes through a two-flop synchronizer before anything inside the block uses it.

When the peripheral is enabled, the pins it owns take their output value from the peripheral's data-out vector. Such a pin drives only if software has set its direction bit and the peripheral also requests output. A peripheral mode fault, where a device set up as master is selected as a slave, releases every peripheral-owned pin in the same cycle. It also clears their direction bits at the next clock edge, so software must set the direction again before those pins drive. The peripheral's serial data input always comes from the synchronized pin level, whatever the direction setting.

Top module: `bidir_pin_port`

## Requirements
- R1: While rst_n is low at a clock edge, the direction bits, the data latch and the open-drain bit are all cleared, so after reset every pin_oe bit is 0 and register reads return 0.
- R2: Register address encoding: 0 is the data latch, 1 is the direction register, 2 is control (bit 0 is the open-drain bit, the other bits read 0), and 3 reads 0 and ignores writes. A write to address 1 is returned unchanged by a later read of address 1.
- R3: A write at address 0 loads the data latch at that clock edge. With the peripheral off, open-drain off and a pin's direction bit at 1, that pin has pin_oe 1 and pin_out equal to its latch bit.
- R4: A pin whose direction bit is 0 has pin_oe 0.
- R5: A read at address 0 returns, for each pin that is effectively an output, the value selected for output on that pin. For every other pin it returns the synchronized pin level.
- R6: With the open-drain bit set, a pin whose output value is 1 has pin_oe 0, and a pin that drives always drives 0.
- R7: With per_en high, peripheral-owned pins (bits 2 to 5 by default) take their output value from per_dout. The other pins keep using the data latch.
- R8: With per_en high, a peripheral-owned pin is effectively an output only when both its direction bit and its per_dir_req bit are 1. The other pins follow their direction bit alone.
- R9: While per_fault is high, every peripheral-owned pin has pin_oe 0 in the same cycle. After a clock edge with per_fault high, the direction bits of owned pins read 0, and the bits of the other pins are kept.
- R10: per_din equals pin_in as it stood two clock edges earlier, whatever the direction setting. A change on pin_in is not visible after only one edge.
- R11: pin_out is 0 on every pin whose pin_oe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Write strobe for the selected register |
| bus_wdata | input | 6 | Write data |
| bus_rdata | output | 6 | Read data of the selected register (combinational) |
| per_en | input | 1 | Peripheral enable, hands owned pins to the peripheral |
| per_dout | input | 6 | Peripheral output values |
| per_dir_req | input | 6 | Peripheral request to drive each pin |
| per_fault | input | 1 | Peripheral mode fault |
| pin_in | input | 6 | Raw pin levels |
| pin_oe | output | 6 | Pin drive enables |
| pin_out | output | 6 | Pin drive values |
| per_din | output | 6 | Synchronized pin levels to the peripheral |

## Verification
A corrupted direction bit shows up in the same cycle as a wrong pin_oe. It also changes the source of a data read, so one read at address 0 with the pin level set opposite to the latch shows which source the read used. A latch or open-drain bit that went wrong shows on pin_out or pin_oe at once, with no pipeline in between. A synchronizer with the wrong depth shows as per_din changing one edge too early or too late, so the bench checks both the edge before the expected change and the edge of the change.

// File: rtl/bpp_pkg.sv
// Shared definitions for the bidirectional port.
// Assumes a two-bit register address.
package bpp_pkg;
    typedef enum logic [1:0] {
        SEL_DATA = 2'd0,
        SEL_DIR  = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/bpp_sync.sv
// Multi-stage synchronizer for the raw pin levels.
// Assumes each pin is sampled on its own, so no bus coherence is promised.
module bpp_sync #(
    parameter int WIDTH  = 6,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    // Shift the pin levels through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= raw_in;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/bpp_regs.sv
// Register file of the port: direction, data latch and open-drain control.
// Assumes one write per cycle. A peripheral fault clears the owned direction bits.
module bpp_regs
    import bpp_pkg::*;
#(
    parameter int               WIDTH       = 6,
    parameter logic [WIDTH-1:0] PERIPH_PINS = 6'b111100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  reg_sel_e         sel,
    input  logic             wr,
    input  logic [WIDTH-1:0] wdata,
    input  logic             per_fault,
    output logic [WIDTH-1:0] dir_q,
    output logic [WIDTH-1:0] latch_q,
    output logic             wired_or_q
);
    // Direction register. A fault wins over a write for the owned pins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= '0;
        end else begin
            if (wr && sel == SEL_DIR) dir_q <= wdata;
            if (per_fault) begin
                if (wr && sel == SEL_DIR) dir_q <= wdata & ~PERIPH_PINS;
                else                      dir_q <= dir_q & ~PERIPH_PINS;
            end
        end
    end

    // Port data latch.
    always_ff @(posedge clk) begin
        if (!rst_n)                       latch_q <= '0;
        else if (wr && sel == SEL_DATA)   latch_q <= wdata;
    end

    // Open-drain control bit, shared by all pins.
    always_ff @(posedge clk) begin
        if (!rst_n)                       wired_or_q <= 1'b0;
        else if (wr && sel == SEL_CTRL)   wired_or_q <= wdata[0];
    end
endmodule

// File: rtl/bpp_pin_cell.sv
// Per-pin output path: source mux, effective direction, open-drain gating
// and read-back source. Purely combinational; OWNED marks a pin the
// peripheral may take over.
module bpp_pin_cell #(
    parameter bit OWNED = 1'b0
) (
    input  logic dir_bit,
    input  logic latch_bit,
    input  logic wired_or,
    input  logic per_en,
    input  logic per_dout,
    input  logic per_req,
    input  logic per_fault,
    input  logic sync_bit,
    output logic oe,
    output logic out,
    output logic rd_bit
);
    localparam logic OWN = OWNED;

    logic take;
    logic out_val;
    logic dir_eff;

    // Choose the output value and the effective direction.
    always_comb begin
        take    = OWN & per_en;
        out_val = take ? per_dout : latch_bit;
        dir_eff = dir_bit & (~take | per_req) & ~(OWN & per_fault);
    end

    // Drive gating: open-drain removes the drive for a one.
    always_comb begin
        oe     = dir_eff & ~(wired_or & out_val);
        out    = oe & out_val;
        rd_bit = dir_eff ? out_val : sync_bit;
    end
endmodule

// File: rtl/bidir_pin_port.sv
// Bidirectional port with peripheral override. Ties the register file,
// the input synchronizer and one pin cell per pin together and muxes
// the register read data. Assumes a synchronous active-low reset.
module bidir_pin_port
    import bpp_pkg::*;
#(
    parameter int               WIDTH       = 6,
    parameter int               SYNC_STAGES = 2,
    parameter logic [WIDTH-1:0] PERIPH_PINS = 6'b111100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       bus_addr,
    input  logic             bus_wr,
    input  logic [WIDTH-1:0] bus_wdata,
    output logic [WIDTH-1:0] bus_rdata,
    input  logic             per_en,
    input  logic [WIDTH-1:0] per_dout,
    input  logic [WIDTH-1:0] per_dir_req,
    input  logic             per_fault,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] pin_oe,
    output logic [WIDTH-1:0] pin_out,
    output logic [WIDTH-1:0] per_din
);
    reg_sel_e         sel;
    logic [WIDTH-1:0] dir_q;
    logic [WIDTH-1:0] latch_q;
    logic             wired_or_q;
    logic [WIDTH-1:0] sync_lvl;
    logic [WIDTH-1:0] rd_bits;

    assign sel = reg_sel_e'(bus_addr);

    bpp_regs #(.WIDTH(WIDTH), .PERIPH_PINS(PERIPH_PINS)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel        (sel),
        .wr         (bus_wr),
        .wdata      (bus_wdata),
        .per_fault  (per_fault),
        .dir_q      (dir_q),
        .latch_q    (latch_q),
        .wired_or_q (wired_or_q)
    );

    bpp_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_in   (pin_in),
        .sync_out (sync_lvl)
    );

    genvar i;
    generate
        for (i = 0; i < WIDTH; i++) begin : g_pin
            bpp_pin_cell #(.OWNED(PERIPH_PINS[i])) u_cell (
                .dir_bit   (dir_q[i]),
                .latch_bit (latch_q[i]),
                .wired_or  (wired_or_q),
                .per_en    (per_en),
                .per_dout  (per_dout[i]),
                .per_req   (per_dir_req[i]),
                .per_fault (per_fault),
                .sync_bit  (sync_lvl[i]),
                .oe        (pin_oe[i]),
                .out       (pin_out[i]),
                .rd_bit    (rd_bits[i])
            );
        end
    endgenerate

    assign per_din = sync_lvl;

    // Register read mux.
    always_comb begin
        case (sel)
            SEL_DATA: bus_rdata = rd_bits;
            SEL_DIR:  bus_rdata = dir_q;
            SEL_CTRL: bus_rdata = {{(WIDTH-1){1'b0}}, wired_or_q};
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/bpp_checker.sv
// Property checker for the bidirectional port, bound to the top module.
// Assumes SYNC_STAGES is 2, as the R10 property is written for that depth.
module bpp_checker #(
    parameter int               WIDTH       = 6,
    parameter logic [WIDTH-1:0] PERIPH_PINS = 6'b111100
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] pin_oe,
    input logic [WIDTH-1:0] pin_out,
    input logic [WIDTH-1:0] pin_in,
    input logic [WIDTH-1:0] per_din,
    input logic             per_fault,
    input logic [WIDTH-1:0] dir_q,
    input logic             wired_or_q
);
    logic [1:0] up_cnt;

    // Count the edges since reset, saturating at 3.
    always_ff @(posedge clk) begin
        if (!rst_n)             up_cnt <= 2'd0;
        else if (up_cnt != 2'd3) up_cnt <= up_cnt + 2'd1;
    end

    // R1: reset clears the direction register.
    a_r1_reset_dir: assert property (@(posedge clk) !rst_n |=> dir_q == '0);

    // R4: no drive without a direction bit.
    a_r4_oe_needs_dir: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe & ~dir_q) == '0);

    // R6: open-drain never drives a one.
    a_r6_no_drive_high: assert property (@(posedge clk) disable iff (!rst_n)
        wired_or_q |-> (pin_oe & pin_out) == '0);

    // R9: fault releases owned pins now and clears their direction next edge.
    a_r9_fault_release: assert property (@(posedge clk) disable iff (!rst_n)
        per_fault |-> (pin_oe & PERIPH_PINS) == '0);
    a_r9_fault_clear: assert property (@(posedge clk) disable iff (!rst_n)
        per_fault |=> (dir_q & PERIPH_PINS) == '0);

    // R10: peripheral input is the pin level two edges earlier.
    a_r10_sync_latency: assert property (@(posedge clk) disable iff (!rst_n)
        up_cnt == 2'd3 |-> per_din == $past(pin_in, 2));

    // R11: the drive value is zero on undriven pins.
    a_r11_quiet_out: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_out & ~pin_oe) == '0);
endmodule

bind bidir_pin_port bpp_checker #(.WIDTH(WIDTH), .PERIPH_PINS(PERIPH_PINS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pin_oe     (pin_oe),
    .pin_out    (pin_out),
    .pin_in     (pin_in),
    .per_din    (per_din),
    .per_fault  (per_fault),
    .dir_q      (dir_q),
    .wired_or_q (wired_or_q)
);

// File: tb/bidir_pin_port_tb.sv
`timescale 1ns/1ps
module bidir_pin_port_tb;
    localparam logic [5:0] MASK = 6'b111100;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_wr = 1'b0;
    logic [5:0] bus_wdata = '0;
    logic [5:0] bus_rdata;
    logic       per_en = 1'b0;
    logic [5:0] per_dout = '0;
    logic [5:0] per_dir_req = '0;
    logic       per_fault = 1'b0;
    logic [5:0] pin_in = '0;
    logic [5:0] pin_oe;
    logic [5:0] pin_out;
    logic [5:0] per_din;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    bidir_pin_port u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .per_en(per_en),
        .per_dout(per_dout), .per_dir_req(per_dir_req), .per_fault(per_fault),
        .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out), .per_din(per_din)
    );

    task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // Write one register; inputs change on the falling edge.
    task automatic wr_reg(input logic [1:0] a, input logic [5:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // Combinational read, sampled away from the edge.
    task automatic rd_reg(input logic [1:0] a, output logic [5:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    initial begin
        logic [5:0] rv;
        logic [5:0] lat;
        logic [5:0] ov;
        logic [5:0] eff;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 oe", pin_oe, 6'd0);
        rd_reg(2'd1, rv); check("R1 dir", rv, 6'd0);
        rd_reg(2'd2, rv); check("R1 ctrl", rv, 6'd0);
        rd_reg(2'd0, rv); check("R1 data", rv, 6'd0);

        // R2: direction register write/read, exhaustive
        for (int v = 0; v < 64; v++) begin
            wr_reg(2'd1, 6'(v));
            rd_reg(2'd1, rv); check("R2 dir readback", rv, 6'(v));
        end

        // R2: address 3 ignores writes and reads zero
        wr_reg(2'd1, 6'b010101);
        wr_reg(2'd0, 6'b001100);
        wr_reg(2'd3, 6'b111111);
        rd_reg(2'd3, rv); check("R2 addr3 read", rv, 6'd0);
        rd_reg(2'd1, rv); check("R2 addr3 dir kept", rv, 6'b010101);
        rd_reg(2'd2, rv); check("R2 addr3 ctrl kept", rv, 6'd0);
        check("R2 addr3 latch kept", pin_out, 6'b000100);

        // R3: all outputs, latch sweep
        wr_reg(2'd1, 6'h3f);
        for (int v = 0; v < 64; v++) begin
            wr_reg(2'd0, 6'(v));
            check("R3 oe", pin_oe, 6'h3f);
            check("R3 out", pin_out, 6'(v));
        end

        // R4, R5, R11: direction sweep with latch and pin level opposed
        lat = 6'b101010;
        wr_reg(2'd0, lat);
        pin_in = 6'b011001;
        repeat (3) @(negedge clk);
        for (int d = 0; d < 64; d++) begin
            wr_reg(2'd1, 6'(d));
            check("R4 oe follows dir", pin_oe, 6'(d));
            check("R11 out gated", pin_out, 6'(d) & lat);
            rd_reg(2'd0, rv);
            check("R5 read source", rv, (6'(d) & lat) | (~6'(d) & pin_in));
        end

        // R6: open-drain, latch sweep
        wr_reg(2'd1, 6'h3f);
        wr_reg(2'd2, 6'd1);
        rd_reg(2'd2, rv); check("R2 ctrl bit", rv, 6'd1);
        for (int v = 0; v < 64; v++) begin
            wr_reg(2'd0, 6'(v));
            check("R6 oe only for zero", pin_oe, ~6'(v));
            check("R6 drives low", pin_out, 6'd0);
        end
        wr_reg(2'd2, 6'd0);

        // R7, R8: peripheral enabled, request sweep
        lat = 6'b110011;
        wr_reg(2'd0, lat);
        wr_reg(2'd1, 6'b101111);
        per_en = 1'b1;
        pin_in = 6'b000000;
        repeat (3) @(negedge clk);
        for (int r = 0; r < 64; r++) begin
            @(negedge clk);
            per_dir_req = 6'(r);
            per_dout = ~6'(r) ^ 6'b000110;
            #0.5;
            ov  = (per_dout & MASK) | (lat & ~MASK);
            eff = 6'b101111 & (6'(r) | ~MASK);
            check("R8 effective dir", pin_oe, eff);
            check("R7 out source", pin_out, eff & ov);
            rd_reg(2'd0, rv);
            check("R5 read with peripheral", rv, eff & ov);
        end

        // R9: fault releases owned pins at once, clears their direction
        wr_reg(2'd1, 6'h3f);
        @(negedge clk);
        per_dir_req = 6'h3f;
        per_fault = 1'b1;
        #0.5;
        check("R9 owned released", pin_oe & MASK, 6'd0);
        check("R9 others driven", pin_oe & ~MASK, 6'b000011);
        @(negedge clk);
        per_fault = 1'b0;
        rd_reg(2'd1, rv); check("R9 dir cleared", rv, 6'b000011);
        check("R9 stays input", pin_oe & MASK, 6'd0);
        per_en = 1'b0;

        // R10: synchronizer latency, with pins driven and undriven
        for (int k = 0; k < 2; k++) begin
            wr_reg(2'd1, k == 0 ? 6'h00 : 6'h3f);
            @(negedge clk);
            pin_in = 6'b100110;
            repeat (3) @(negedge clk);
            check("R10 settled", per_din, 6'b100110);
            pin_in = 6'b011011;
            @(negedge clk);
            check("R10 not after one edge", per_din, 6'b100110);
            @(negedge clk);
            check("R10 after two edges", per_din, 6'b011011);
        end

        // R1: reset mid-run clears everything
        wr_reg(2'd2, 6'd1);
        wr_reg(2'd0, 6'h15);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 oe after reset", pin_oe, 6'd0);
        rd_reg(2'd1, rv); check("R1 dir after reset", rv, 6'd0);
        rd_reg(2'd2, rv); check("R1 ctrl after reset", rv, 6'd0);
        wr_reg(2'd1, 6'h3f);
        check("R1 latch after reset", pin_out, 6'd0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    // Watchdog: an expired run counts as one failed check.
    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule